// File: doc/BRIEF.md
# Keyed Flash Block Program Sequencer

This block carries out block-sized program and erase jobs on an internal flash-array model. Each job covers one block of 64 bytes. A request names the operation, a block number, a key byte, a second key byte that is handed back on success, an SRAM start pointer (used only by program jobs), a pulse-length divider, and whether the request comes from outside the chip or from inside. Before it touches anything, the sequencer checks the key and looks up the block's two-bit protection level. A request that fails either check ends with a fixed failure status and leaves the array unchanged.

A request that passes runs a program pulse of divider length. The sequencer then commits the block one byte per cycle in ascending order. A program job takes the bytes from a 256-byte SRAM model. An erase job writes the erased value FFh. Protection levels are raised through a separate port that ORs new bits into the stored level. Only reset lowers them. The SRAM model has a write port, and both the array and the protection table have read ports, so the surrounding logic can load data and inspect results.

Top module: `flash_blk_seq`

## Requirements
- R1: A program job with pointer P stores SRAM byte at address (P+i) mod 256 into byte i of the target block for i = 0..63, written in ascending i, one byte per cycle; req_op = 0 selects program.
- R2: An erase job (req_op = 1) sets all 64 bytes of the target block to FFh and changes no byte of any other block.
- R3: A request whose key byte is not 3Ah is rejected: st_acc = 00h, st_key2 = 00h, st_key1 = 01h, and no array byte changes.
- R4: Protection levels are 0 (open), 1 (read lock), 2 (external write lock) and 3 (full lock). A request with req_ext = 1 is rejected at levels 2 and 3. A request with req_ext = 0 is rejected only at level 3. A rejection gives the same status as R3 and no array change.
- R5: A request whose block number is not below NUM_BLK (16 by default) is rejected with the R3 status and no array change.
- R6: A job that completes reports st_acc = 00h, st_key1 = 00h, and st_key2 equal to the key-2 byte supplied with the request.
- R7: done is high for exactly one cycle. A rejected request raises done 1 cycle after the accepting edge. A completed job raises done D+65 cycles after it, where D is the divider value (0 taken as 1). pgm_pulse is high for exactly D cycles of a completed job and never for a rejected one. busy stays high from acceptance until done and is low while done is high.
- R8: A protection write ORs prot_lvl into the stored level of block prot_blk and is ignored for blocks at or above NUM_BLK. Such blocks read back level 0. An erase never changes any protection level.
- R9: req_valid is ignored while a job is in progress: the running job's result is unaffected.
- R10: After reset, busy, done and all status bytes are 0 and every protection level reads 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| req_valid | input | 1 | Request strobe, taken when idle |
| req_op | input | 1 | 0 program, 1 erase |
| req_ext | input | 1 | Request originates outside the chip |
| req_key1 | input | 8 | Key byte, must be 3Ah |
| req_key2 | input | 8 | Byte echoed in st_key2 on success |
| req_blk | input | 7 | Target block number |
| req_ptr | input | 8 | SRAM start address for program jobs |
| req_clkdiv | input | 8 | Pulse length in clock cycles (0 treated as 1) |
| busy | output | 1 | Job in progress |
| done | output | 1 | One-cycle completion strobe |
| pgm_pulse | output | 1 | Program or erase pulse |
| st_acc | output | 8 | Status accumulator byte |
| st_key1 | output | 8 | Status byte, 01h on failure |
| st_key2 | output | 8 | Status byte, key-2 echo on success |
| sram_we | input | 1 | SRAM model write enable |
| sram_waddr | input | 8 | SRAM model write address |
| sram_wdata | input | 8 | SRAM model write data |
| prot_we | input | 1 | Protection level OR-write enable |
| prot_blk | input | 7 | Block for protection write |
| prot_lvl | input | 2 | Level bits ORed in |
| prot_rblk | input | 7 | Block for protection readback |
| prot_rlvl | output | 2 | Protection level readback |
| fl_raddr | input | FA_W (10) | Array readback byte address, block*64+offset |
| fl_rdata | output | 8 | Array readback data |

## Verification
A rejected request raises done after one edge, and a completed job raises it after D+65 edges. The bench counts edges from the accepting edge, sampling 1 ns after each edge, and compares that count with the value it computes from the divider and the expected verdict. During the same walk it counts the cycles with pgm_pulse high and checks that busy stays high. Status bytes are read in the done cycle, and the bench checks that done has dropped one edge later. The array and protection read ports are combinational, so the whole expected image is compared after each job once the sequencer is idle again.

// File: rtl/fbs_pkg.sv
package fbs_pkg;
  localparam int          BLK_BYTES = 64;
  localparam logic [7:0]  KEY_OK    = 8'h3A;
  localparam logic [7:0]  FAIL_CODE = 8'h01;
  localparam logic [7:0]  ERASE_VAL = 8'hFF;

  typedef enum logic [2:0] {
    S_IDLE  = 3'd0,
    S_CHECK = 3'd1,
    S_PULSE = 3'd2,
    S_COPY  = 3'd3,
    S_FIN   = 3'd4
  } seq_state_e;

  // level 3 locks everyone, level 2 locks external requesters only
  function automatic logic may_write(input logic [1:0] lvl, input logic ext);
    return (lvl != 2'd3) && !(ext && (lvl == 2'd2));
  endfunction
endpackage

// File: rtl/fbs_sram.sv
module fbs_sram #(
  parameter int AW = 8,
  parameter int DW = 8,
  localparam int DEPTH = 1 << AW
) (
  input  logic          clk,
  input  logic          we,
  input  logic [AW-1:0] waddr,
  input  logic [DW-1:0] wdata,
  input  logic [AW-1:0] raddr,
  output logic [DW-1:0] rdata
);
  logic [DW-1:0] mem_q [DEPTH];

  always_ff @(posedge clk) begin
    if (we) mem_q[waddr] <= wdata;
  end

  assign rdata = mem_q[raddr];
endmodule

// File: rtl/fbs_array.sv
module fbs_array #(
  parameter int NUM_BLK = 16,
  parameter int DW      = 8,
  localparam int BLK_W  = $clog2(NUM_BLK),
  localparam int FA_W   = $clog2(NUM_BLK * fbs_pkg::BLK_BYTES),
  localparam int BYTES  = NUM_BLK * fbs_pkg::BLK_BYTES
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             wr_en,
  input  logic [FA_W-1:0]  wr_addr,
  input  logic [DW-1:0]    wr_data,
  input  logic [FA_W-1:0]  rd_addr,
  output logic [DW-1:0]    rd_data,
  input  logic             prot_we,
  input  logic [BLK_W-1:0] prot_blk,
  input  logic [1:0]       prot_lvl,
  input  logic [BLK_W-1:0] chk_blk,
  output logic [1:0]       chk_lvl,
  input  logic [BLK_W-1:0] prot_rblk,
  output logic [1:0]       prot_rlvl
);
  logic [DW-1:0] mem_q  [BYTES];
  logic [1:0]    prot_q [NUM_BLK];

  // array cells carry no reset: contents are undefined until written
  always_ff @(posedge clk) begin
    if (wr_en) mem_q[wr_addr] <= wr_data;
  end

  for (genvar g = 0; g < NUM_BLK; g++) begin : g_prot
    logic hit;
    assign hit = prot_we && (prot_blk == BLK_W'(g));
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)   prot_q[g] <= 2'b00;
      else if (hit) prot_q[g] <= prot_q[g] | prot_lvl;
    end
  end

  assign rd_data   = mem_q[rd_addr];
  assign chk_lvl   = prot_q[chk_blk];
  assign prot_rlvl = prot_q[prot_rblk];

  // R8: bits written into a level are present one cycle later and never dropped
  a_r8_or_sticky: assert property (@(posedge clk) disable iff (!rst_n)
    prot_we |=> ((prot_q[$past(prot_blk)] & $past(prot_lvl)) == $past(prot_lvl)));
endmodule

// File: rtl/fbs_ctrl.sv
module fbs_ctrl
  import fbs_pkg::*;
#(
  parameter int NUM_BLK = 16,
  parameter int BN_W    = 7,
  parameter int PTR_W   = 8,
  parameter int DIV_W   = 8,
  localparam int BLK_W  = $clog2(NUM_BLK),
  localparam int IDX_W  = $clog2(BLK_BYTES),
  localparam int FA_W   = BLK_W + IDX_W
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             req_valid,
  input  logic             req_op,
  input  logic             req_ext,
  input  logic [7:0]       req_key1,
  input  logic [7:0]       req_key2,
  input  logic [BN_W-1:0]  req_blk,
  input  logic [PTR_W-1:0] req_ptr,
  input  logic [DIV_W-1:0] req_clkdiv,
  output logic [BLK_W-1:0] chk_blk,
  input  logic [1:0]       chk_lvl,
  output logic [PTR_W-1:0] sr_raddr,
  input  logic [7:0]       sr_rdata,
  output logic             fl_we,
  output logic [FA_W-1:0]  fl_waddr,
  output logic [7:0]       fl_wdata,
  output logic             busy,
  output logic             done,
  output logic             pgm_pulse,
  output logic [7:0]       st_acc,
  output logic [7:0]       st_key1,
  output logic [7:0]       st_key2
);
  seq_state_e       st_q, st_d;
  logic [DIV_W-1:0] cnt_q, cnt_d;
  logic [IDX_W-1:0] idx_q, idx_d;
  logic [BN_W-1:0]  blk_q;
  logic [PTR_W-1:0] ptr_q;
  logic             op_q, ext_q;
  logic [7:0]       key1_q, key2_q;
  logic [7:0]       acc_q, k1_q, k2_q, acc_d, k1_d, k2_d;
  logic             stat_en, accept;
  logic             blk_ok, key_ok, perm_ok;

  assign accept  = (st_q == S_IDLE) && req_valid;
  assign blk_ok  = int'(blk_q) < NUM_BLK;
  assign key_ok  = key1_q == KEY_OK;
  assign perm_ok = may_write(chk_lvl, ext_q);

  // next-state process
  always_comb begin
    st_d    = st_q;
    cnt_d   = cnt_q;
    idx_d   = idx_q;
    stat_en = 1'b0;
    acc_d   = 8'h00;
    k1_d    = 8'h00;
    k2_d    = 8'h00;
    fl_we   = 1'b0;
    unique case (st_q)
      S_IDLE: begin
        idx_d = '0;
        if (req_valid) begin
          st_d  = S_CHECK;
          cnt_d = (req_clkdiv == '0) ? DIV_W'(1) : req_clkdiv;
        end
      end
      S_CHECK: begin
        if (key_ok && blk_ok && perm_ok) begin
          st_d = S_PULSE;
        end else begin
          st_d    = S_FIN;
          stat_en = 1'b1;
          k1_d    = FAIL_CODE;
        end
      end
      S_PULSE: begin
        cnt_d = cnt_q - DIV_W'(1);
        if (cnt_q == DIV_W'(1)) st_d = S_COPY;
      end
      S_COPY: begin
        fl_we = 1'b1;
        idx_d = idx_q + IDX_W'(1);
        if (idx_q == {IDX_W{1'b1}}) begin
          st_d    = S_FIN;
          stat_en = 1'b1;
          k2_d    = key2_q;
        end
      end
      S_FIN:   st_d = S_IDLE;
      default: st_d = S_IDLE;
    endcase
  end

  // register process
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st_q  <= S_IDLE;
      cnt_q <= '0;
      idx_q <= '0;
    end else begin
      st_q  <= st_d;
      cnt_q <= cnt_d;
      idx_q <= idx_d;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      blk_q  <= '0;
      ptr_q  <= '0;
      op_q   <= 1'b0;
      ext_q  <= 1'b0;
      key1_q <= 8'h00;
      key2_q <= 8'h00;
    end else if (accept) begin
      blk_q  <= req_blk;
      ptr_q  <= req_ptr;
      op_q   <= req_op;
      ext_q  <= req_ext;
      key1_q <= req_key1;
      key2_q <= req_key2;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      acc_q <= 8'h00;
      k1_q  <= 8'h00;
      k2_q  <= 8'h00;
    end else if (stat_en) begin
      acc_q <= acc_d;
      k1_q  <= k1_d;
      k2_q  <= k2_d;
    end
  end

  assign chk_blk   = blk_q[BLK_W-1:0];
  assign sr_raddr  = ptr_q + PTR_W'(idx_q);
  assign fl_waddr  = {blk_q[BLK_W-1:0], idx_q};
  assign fl_wdata  = op_q ? ERASE_VAL : sr_rdata;
  assign busy      = (st_q == S_CHECK) || (st_q == S_PULSE) || (st_q == S_COPY);
  assign done      = st_q == S_FIN;
  assign pgm_pulse = st_q == S_PULSE;
  assign st_acc    = acc_q;
  assign st_key1   = k1_q;
  assign st_key2   = k2_q;

  a_r7_done_single: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> !done);
  a_r7_busy_done_excl: assert property (@(posedge clk) disable iff (!rst_n)
    !(busy && done));
  a_r7_copy_follows_pulse: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(pgm_pulse) |-> fl_we);
  a_r1_ascending: assert property (@(posedge clk) disable iff (!rst_n)
    (fl_we && $past(fl_we)) |-> (fl_waddr == $past(fl_waddr) + FA_W'(1)));
  a_r3_fail_fields: assert property (@(posedge clk) disable iff (!rst_n)
    (done && st_key1 == FAIL_CODE) |-> (st_acc == 8'h00 && st_key2 == 8'h00));
  a_r9_target_stable: assert property (@(posedge clk) disable iff (!rst_n)
    (busy && $past(busy)) |-> ($stable(chk_blk) && $stable(sr_raddr - PTR_W'(idx_q))));
endmodule

// File: rtl/flash_blk_seq.sv
module flash_blk_seq #(
  parameter int NUM_BLK = 16,
  localparam int FA_W   = $clog2(NUM_BLK * fbs_pkg::BLK_BYTES),
  localparam int BLK_W  = $clog2(NUM_BLK)
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            req_valid,
  input  logic            req_op,
  input  logic            req_ext,
  input  logic [7:0]      req_key1,
  input  logic [7:0]      req_key2,
  input  logic [6:0]      req_blk,
  input  logic [7:0]      req_ptr,
  input  logic [7:0]      req_clkdiv,
  output logic            busy,
  output logic            done,
  output logic            pgm_pulse,
  output logic [7:0]      st_acc,
  output logic [7:0]      st_key1,
  output logic [7:0]      st_key2,
  input  logic            sram_we,
  input  logic [7:0]      sram_waddr,
  input  logic [7:0]      sram_wdata,
  input  logic            prot_we,
  input  logic [6:0]      prot_blk,
  input  logic [1:0]      prot_lvl,
  input  logic [6:0]      prot_rblk,
  output logic [1:0]      prot_rlvl,
  input  logic [FA_W-1:0] fl_raddr,
  output logic [7:0]      fl_rdata
);
  logic [1:0]       rs_q;
  logic             rst_int_n;
  logic [BLK_W-1:0] chk_blk;
  logic [1:0]       chk_lvl, arr_rlvl;
  logic [7:0]       sr_raddr, sr_rdata;
  logic             fl_we;
  logic [FA_W-1:0]  fl_waddr;
  logic [7:0]       fl_wdata;
  logic             prot_we_ok, prot_rd_ok;

  // asynchronous assertion, synchronous release
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rs_q <= 2'b00;
    else        rs_q <= {rs_q[0], 1'b1};
  end
  assign rst_int_n = rs_q[1];

  assign prot_we_ok = prot_we && (int'(prot_blk) < NUM_BLK);
  assign prot_rd_ok = int'(prot_rblk) < NUM_BLK;
  assign prot_rlvl  = prot_rd_ok ? arr_rlvl : 2'b00;

  fbs_sram #(.AW(8), .DW(8)) u_sram (
    .clk   (clk),
    .we    (sram_we),
    .waddr (sram_waddr),
    .wdata (sram_wdata),
    .raddr (sr_raddr),
    .rdata (sr_rdata)
  );

  fbs_array #(.NUM_BLK(NUM_BLK), .DW(8)) u_array (
    .clk       (clk),
    .rst_n     (rst_int_n),
    .wr_en     (fl_we),
    .wr_addr   (fl_waddr),
    .wr_data   (fl_wdata),
    .rd_addr   (fl_raddr),
    .rd_data   (fl_rdata),
    .prot_we   (prot_we_ok),
    .prot_blk  (prot_blk[BLK_W-1:0]),
    .prot_lvl  (prot_lvl),
    .chk_blk   (chk_blk),
    .chk_lvl   (chk_lvl),
    .prot_rblk (prot_rblk[BLK_W-1:0]),
    .prot_rlvl (arr_rlvl)
  );

  fbs_ctrl #(.NUM_BLK(NUM_BLK), .BN_W(7), .PTR_W(8), .DIV_W(8)) u_ctrl (
    .clk        (clk),
    .rst_n      (rst_int_n),
    .req_valid  (req_valid),
    .req_op     (req_op),
    .req_ext    (req_ext),
    .req_key1   (req_key1),
    .req_key2   (req_key2),
    .req_blk    (req_blk),
    .req_ptr    (req_ptr),
    .req_clkdiv (req_clkdiv),
    .chk_blk    (chk_blk),
    .chk_lvl    (chk_lvl),
    .sr_raddr   (sr_raddr),
    .sr_rdata   (sr_rdata),
    .fl_we      (fl_we),
    .fl_waddr   (fl_waddr),
    .fl_wdata   (fl_wdata),
    .busy       (busy),
    .done       (done),
    .pgm_pulse  (pgm_pulse),
    .st_acc     (st_acc),
    .st_key1    (st_key1),
    .st_key2    (st_key2)
  );
endmodule

// File: tb/sim_flash_blk_seq.sv
module sim_flash_blk_seq;
  localparam int NB    = 16;
  localparam int BYTES = NB * 64;

  logic clk = 1'b0;
  logic rst_n;
  logic req_valid, req_op, req_ext;
  logic [7:0] req_key1, req_key2, req_ptr, req_clkdiv;
  logic [6:0] req_blk;
  logic busy, done, pgm_pulse;
  logic [7:0] st_acc, st_key1, st_key2;
  logic sram_we;
  logic [7:0] sram_waddr, sram_wdata;
  logic prot_we;
  logic [6:0] prot_blk, prot_rblk;
  logic [1:0] prot_lvl, prot_rlvl;
  logic [9:0] fl_raddr;
  logic [7:0] fl_rdata;

  int tests = 0;
  int fails = 0;
  logic [7:0] sm [256];
  logic [7:0] fm [BYTES];
  bit         fk [BYTES];
  logic [1:0] pm [NB];

  always #10 clk = ~clk;

  flash_blk_seq #(.NUM_BLK(NB)) u0 (
    .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_op(req_op), .req_ext(req_ext),
    .req_key1(req_key1), .req_key2(req_key2), .req_blk(req_blk), .req_ptr(req_ptr),
    .req_clkdiv(req_clkdiv), .busy(busy), .done(done), .pgm_pulse(pgm_pulse),
    .st_acc(st_acc), .st_key1(st_key1), .st_key2(st_key2), .sram_we(sram_we),
    .sram_waddr(sram_waddr), .sram_wdata(sram_wdata), .prot_we(prot_we),
    .prot_blk(prot_blk), .prot_lvl(prot_lvl), .prot_rblk(prot_rblk),
    .prot_rlvl(prot_rlvl), .fl_raddr(fl_raddr), .fl_rdata(fl_rdata)
  );

  task automatic chk(input bit ok, input string tag, input string what,
                     input int act, input int exp);
    tests++;
    if (!ok) begin
      fails++;
      $display("FAIL %s %s: actual %0h expected %0h", tag, what, act, exp);
    end
  endtask

  function automatic bit exp_perm(input logic [1:0] l, input bit ext);
    return (l != 2'd3) && !(ext && l == 2'd2);
  endfunction

  task automatic fill_sram();
    for (int i = 0; i < 256; i++) begin
      @(negedge clk);
      sram_we = 1'b1; sram_waddr = 8'(i); sram_wdata = 8'($urandom);
      sm[i] = sram_wdata;
    end
    @(negedge clk); sram_we = 1'b0;
  endtask

  task automatic set_prot(input logic [6:0] b, input logic [1:0] l);
    @(negedge clk);
    prot_we = 1'b1; prot_blk = b; prot_lvl = l;
    @(negedge clk);
    prot_we = 1'b0;
    if (b < NB) pm[b[3:0]] = pm[b[3:0]] | l;
  endtask

  task automatic check_prot(input string tag);
    int bad = 0;
    for (int b = 0; b < NB + 4; b++) begin
      prot_rblk = 7'(b); #1;
      if (prot_rlvl !== ((b < NB) ? pm[b] : 2'd0)) bad++;
    end
    chk(bad == 0, tag, "protection readback mismatches", bad, 0);
  endtask

  task automatic check_array(input string tag);
    int bad = 0;
    int first = -1;
    for (int a = 0; a < BYTES; a++) begin
      if (fk[a]) begin
        fl_raddr = 10'(a); #1;
        if (fl_rdata !== fm[a]) begin
          bad++;
          if (first < 0) first = a;
        end
      end
    end
    chk(bad == 0, tag, $sformatf("array mismatches (first at %0d)", first), bad, 0);
  endtask

  task automatic do_op(input bit op, input bit ext, input logic [7:0] k1,
                       input logic [7:0] k2, input logic [6:0] blk,
                       input logic [7:0] ptr, input logic [7:0] div,
                       input bit poke, input string tag);
    bit ok;
    int d, n, pc;
    bit busy_bad;
    ok = (k1 == 8'h3A) && (blk < NB) && exp_perm((blk < NB) ? pm[blk[3:0]] : 2'd0, ext);
    d  = (div == 0) ? 1 : int'(div);
    @(negedge clk);
    req_valid = 1'b1; req_op = op; req_ext = ext; req_key1 = k1; req_key2 = k2;
    req_blk = blk; req_ptr = ptr; req_clkdiv = div;
    @(posedge clk); #1;
    req_valid = 1'b0;
    n = 0; pc = 0; busy_bad = 0;
    while (!done && n < 600) begin
      @(posedge clk); #1; n++;
      if (pgm_pulse) pc++;
      if (!done && !busy) busy_bad = 1;
      if (poke && n == 2) begin
        req_valid = 1'b1; req_op = ~op; req_blk = blk ^ 7'd1; req_ptr = ptr + 8'd7;
      end else if (poke && n == 3) begin
        req_valid = 1'b0;
      end
    end
    req_valid = 1'b0;
    chk(n == (ok ? d + 65 : 1), "R7", "edges to done", n, ok ? d + 65 : 1);
    chk(pc == (ok ? d : 0), "R7", "pulse cycles", pc, ok ? d : 0);
    chk(!busy_bad && !busy, "R7", "busy until done", int'(busy_bad), 0);
    chk(st_acc == 8'h00, ok ? "R6" : tag, "st_acc", st_acc, 0);
    chk(st_key1 == (ok ? 8'h00 : 8'h01), ok ? "R6" : tag, "st_key1", st_key1, ok ? 0 : 1);
    chk(st_key2 == (ok ? k2 : 8'h00), ok ? "R6" : tag, "st_key2", st_key2, ok ? k2 : 0);
    @(posedge clk); #1;
    chk(!done, "R7", "done single cycle", int'(done), 0);
    if (ok) begin
      for (int i = 0; i < 64; i++) begin
        fm[int'(blk) * 64 + i] = op ? 8'hFF : sm[8'(ptr + 8'(i))];
        fk[int'(blk) * 64 + i] = 1'b1;
      end
    end
    check_array(poke ? "R9" : (ok ? (op ? "R2" : "R1") : tag));
    check_prot("R8");
  endtask

  initial begin : watchdog
    repeat (200000) @(posedge clk);
    fails++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("  [TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end

  initial begin : stim
    void'($urandom(32'd4711));
    rst_n = 1'b0; req_valid = 0; req_op = 0; req_ext = 0; req_key1 = 0; req_key2 = 0;
    req_blk = 0; req_ptr = 0; req_clkdiv = 0; sram_we = 0; sram_waddr = 0; sram_wdata = 0;
    prot_we = 0; prot_blk = 0; prot_lvl = 0; prot_rblk = 0; fl_raddr = 0;
    for (int i = 0; i < NB; i++) pm[i] = 2'd0;
    for (int i = 0; i < BYTES; i++) begin fk[i] = 1'b0; fm[i] = 8'h00; end
    repeat (3) @(posedge clk);
    #3 rst_n = 1'b1;
    repeat (4) @(posedge clk);
    #1;
    // R10: reset state
    chk(!busy && !done && !pgm_pulse, "R10", "control outputs", {busy, done, pgm_pulse}, 0);
    chk(st_acc == 0 && st_key1 == 0 && st_key2 == 0, "R10", "status bytes",
        {st_acc, st_key1, st_key2}, 0);
    check_prot("R10");

    fill_sram();
    // R2: erase every block so the whole array is known
    for (int b = 0; b < NB; b++) do_op(1'b1, 1'b0, 8'h3A, 8'(b), 7'(b), 8'h00, 8'(b % 3), 0, "R2");
    // R1: pointer wrap, divider 0
    do_op(1'b0, 1'b0, 8'h3A, 8'h5C, 7'd3, 8'hF0, 8'd0, 0, "R1");
    do_op(1'b0, 1'b1, 8'h3A, 8'hA7, 7'd15, 8'h11, 8'd9, 0, "R1");
    // R3: wrong key
    do_op(1'b0, 1'b0, 8'h3B, 8'h44, 7'd4, 8'h20, 8'd2, 0, "R3");
    do_op(1'b1, 1'b0, 8'h00, 8'h44, 7'd3, 8'h20, 8'd2, 0, "R3");
    // R5: block past the array
    do_op(1'b1, 1'b0, 8'h3A, 8'h12, 7'd16, 8'h00, 8'd1, 0, "R5");
    do_op(1'b0, 1'b0, 8'h3A, 8'h12, 7'h7F, 8'h00, 8'd1, 0, "R5");
    // R8: OR semantics, out-of-range write ignored
    set_prot(7'd7, 2'd1);
    set_prot(7'd6, 2'd2);
    set_prot(7'd20, 2'd3);
    check_prot("R8");
    // R4: external lock and full lock
    do_op(1'b0, 1'b1, 8'h3A, 8'h01, 7'd6, 8'h40, 8'd1, 0, "R4");
    do_op(1'b0, 1'b0, 8'h3A, 8'h02, 7'd6, 8'h40, 8'd1, 0, "R4");
    set_prot(7'd6, 2'd1);
    do_op(1'b1, 1'b0, 8'h3A, 8'h03, 7'd6, 8'h40, 8'd1, 0, "R4");
    do_op(1'b1, 1'b1, 8'h3A, 8'h04, 7'd7, 8'h00, 8'd2, 0, "R4");
    // R8: erase of a level-1 block keeps its level (checked inside do_op)
    do_op(1'b1, 1'b0, 8'h3A, 8'h05, 7'd7, 8'h00, 8'd1, 0, "R8");
    // R9: request during a job
    do_op(1'b0, 1'b0, 8'h3A, 8'h66, 7'd2, 8'h80, 8'd3, 1, "R9");

    // random mix
    for (int t = 0; t < 24; t++) begin
      if ($urandom_range(0, 3) == 0)
        set_prot(7'($urandom_range(0, 19)), ($urandom_range(0, 7) == 0) ? 2'd3 : 2'($urandom_range(0, 2)));
      do_op(1'($urandom), 1'($urandom),
            ($urandom_range(0, 9) == 0) ? 8'($urandom) : 8'h3A,
            8'($urandom), 7'($urandom_range(0, 17)), 8'($urandom),
            8'($urandom_range(0, 4)), ($urandom_range(0, 4) == 0), "R4");
    end

    $display("  [TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end
endmodule